// File: doc/BRIEF.md
# Activity-Triggered Power-Down Timer

This block decides when a memory array may sit in its low-power state. It watches the memory's chip select, write strobe, address and data lines. A wake event is any of these: chip select going active, the write strobe going active while the chip is selected, an address change while selected, a data change during a selected write, or an explicit clear request. Each wake event loads a countdown with a fixed hold time, measured in clock cycles.

The memory is reported awake while the countdown is nonzero. It falls back to sleep when the countdown runs out, even if chip select stays active. Power use therefore follows how often the inputs change, not how long the select line is held.

Changes are found by comparing each input with a copy registered one clock earlier. A single-cycle pulse reports every change from awake to sleep caused by the timer running out.

Top module: `pdt_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `awake`=0, `sleep`=1 and `sleep_pulse`=0 after that edge, and a reset never produces a `sleep_pulse`.
- R2: `ce_n` sampled 1 at one edge and 0 at the next is a wake event.
- R3: `we_n` sampled 1 then 0 is a wake event only if `ce_n` is 0 at the second sample.
- R4: `addr` differing from its value at the previous edge is a wake event only if `ce_n` is 0.
- R5: `data` differing from its value at the previous edge is a wake event only if `ce_n` and `we_n` are both 0.
- R6: `clr` high at an edge is a wake event whatever the other inputs are.
- R7: After a wake event at edge k, `awake` is 1 for exactly HOLD cycles (edges k to k+HOLD-1) and is 0 after edge k+HOLD, even with `ce_n` held at 0. A new wake event reloads the full HOLD count.
- R8: `sleep` is always the inverse of `awake`.
- R9: `sleep_pulse` is 1 for exactly the one cycle in which `awake` first reads 0 after the countdown expires, and is 0 at all other times.
- R10: `ce_n` or `we_n` going from 0 to 1, and input changes while a gate condition from R3 to R5 is false, are not wake events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Memory chip select, active low |
| we_n | input | 1 | Memory write strobe, active low |
| addr | input | AW | Memory address bus |
| data | input | DW | Memory data bus |
| clr | input | 1 | Clear request, active high, forces wake |
| awake | output | 1 | Power-up flag |
| sleep | output | 1 | Low-power flag |
| sleep_pulse | output | 1 | One-cycle pulse on each timeout into sleep |

## Verification
The bench holds `ce_n` low long past the hold time. A design that tied power to the select level would never go to sleep there. It toggles the write strobe and the address while the chip is deselected, and changes data while the write strobe is inactive. A design missing a gate would wake on these changes. It retriggers two cycles before expiry to show that a design which does not reload the full count falls asleep early. It also asserts reset in the middle of an awake window, where a design that misreports the transition would emit a spurious sleep pulse.

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;

  typedef struct packed {
    logic sel_fall;
    logic wr_fall;
    logic adr_move;
    logic dat_move;
  } pdt_events_t;

  // Countdown step: a wake reloads the hold, otherwise count toward zero.
  function automatic logic [31:0] pdt_next_count(input logic [31:0] cur,
                                                 input logic        wake,
                                                 input logic [31:0] hold);
    if (wake)           return hold;
    else if (cur != 0)  return cur - 32'd1;
    else                return 32'd0;
  endfunction

  // True when the coming edge takes the counter from one to zero.
  function automatic logic pdt_expiring(input logic [31:0] cur, input logic wake);
    return (cur == 32'd1) && !wake;
  endfunction

endpackage

// File: rtl/pdt_activity_detect.sv
`timescale 1ns/1ps
module pdt_activity_detect #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 ce_n,
  input  logic                 we_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        data,
  output pdt_pkg::pdt_events_t events
);
  logic          ce_n_q;
  logic          we_n_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // Previous-cycle copies; sampled every cycle, including during reset,
  // so that the first cycle after reset compares against real values.
  always_ff @(posedge clk) begin
    ce_n_q <= ce_n;
    we_n_q <= we_n;
    addr_q <= addr;
    data_q <= data;
  end

  logic selected;
  logic writing;
  assign selected = !ce_n;
  assign writing  = selected && !we_n;

  always_comb begin
    events.sel_fall = ce_n_q && !ce_n;
    events.wr_fall  = we_n_q && !we_n && selected;
    events.adr_move = (addr != addr_q) && selected;
    events.dat_move = (data != data_q) && writing;
  end
endmodule

// File: rtl/pdt_hold_timer.sv
`timescale 1ns/1ps
module pdt_hold_timer #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  output logic awake,
  output logic sleep_pulse
);
  import pdt_pkg::*;

  localparam int HOLD_EFF = (HOLD < 1) ? 1 : HOLD;
  localparam int CW       = $clog2(HOLD_EFF + 1);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          expiring;

  assign count_d  = CW'(pdt_next_count(32'(count_q), wake, 32'(HOLD_EFF)));
  assign expiring = pdt_expiring(32'(count_q), wake);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      sleep_pulse <= 1'b0;
    end else begin
      count_q     <= count_d;
      sleep_pulse <= expiring;
    end
  end

  assign awake = (count_q != '0);
endmodule

// File: rtl/pdt_top.sv
`timescale 1ns/1ps
module pdt_top #(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int HOLD = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          clr,
  output logic          awake,
  output logic          sleep,
  output logic          sleep_pulse
);
  import pdt_pkg::*;

  pdt_events_t events;
  logic        trigger;

  pdt_activity_detect #(.AW(AW), .DW(DW)) u_detect (
    .clk    (clk),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .addr   (addr),
    .data   (data),
    .events (events)
  );

  assign trigger = (|events) || clr;

  pdt_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .wake        (trigger),
    .awake       (awake),
    .sleep_pulse (sleep_pulse)
  );

  assign sleep = !awake;
endmodule

// File: rtl/pdt_checker.sv
`timescale 1ns/1ps
module pdt_checker (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic clr,
  input logic trigger,
  input logic awake,
  input logic sleep_pulse
);
  assert_reset_down_R1: assert property (@(posedge clk)
    rst |=> (!awake && !sleep_pulse));

  assert_ce_fall_wakes_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_n) && !ce_n) |=> awake);

  assert_clr_wakes_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> awake);

  assert_trigger_wakes_R7: assert property (@(posedge clk) disable iff (rst)
    trigger |=> awake);

  assert_no_drop_after_trigger_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(awake)) |-> !$past(trigger));

  assert_pulse_on_drop_R9: assert property (@(posedge clk) disable iff (rst)
    sleep_pulse |-> (!awake && $past(awake)));

  assert_drop_gives_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(awake)) |-> sleep_pulse);
endmodule

bind pdt_top pdt_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce_n        (ce_n),
  .clr         (clr),
  .trigger     (trigger),
  .awake       (awake),
  .sleep_pulse (sleep_pulse)
);

// File: tb/tb_pdt_top.sv
`timescale 1ns/1ps
module tb_pdt_top;
  localparam int AW   = 4;
  localparam int DW   = 4;
  localparam int HOLD = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          clr = 1'b0;
  logic          awake, sleep, sleep_pulse;

  always #2 clk = ~clk;

  pdt_top #(.AW(AW), .DW(DW), .HOLD(HOLD)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .data(data), .clr(clr), .awake(awake), .sleep(sleep),
    .sleep_pulse(sleep_pulse)
  );

  typedef struct {
    logic  aw;
    logic  pl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Reference model state
  int            m_left  = 0;
  logic          m_pce   = 1'b1;
  logic          m_pwe   = 1'b1;
  logic [AW-1:0] m_paddr = '0;
  logic [DW-1:0] m_pdata = '0;

  task automatic step(input logic r, input logic c, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic k, input string tag);
    exp_t e;
    logic wake;
    @(negedge clk);
    rst = r; ce_n = c; we_n = w; addr = a; data = d; clr = k;
    wake = !r && ( k
                || (m_pce && !c)
                || (!c && m_pwe && !w)
                || (!c && (a != m_paddr))
                || (!c && !w && (d != m_pdata)) );
    e.pl = !r && (m_left == 1) && !wake;
    if (r)             m_left = 0;
    else if (wake)     m_left = HOLD;
    else if (m_left > 0) m_left = m_left - 1;
    e.aw  = (m_left > 0);
    e.tag = tag;
    m_pce = c; m_pwe = w; m_paddr = a; m_pdata = d;
    q.push_back(e);
  endtask

  // Monitor: compares each result just after the edge it belongs to.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0 && !done) begin
      e = q.pop_front();
      checks++;
      if (awake !== e.aw || sleep !== !e.aw || sleep_pulse !== e.pl) begin
        fails++;
        $display("FAIL %s: awake/sleep/pulse=%b%b%b expected %b%b%b",
                 e.tag, awake, sleep, sleep_pulse, e.aw, !e.aw, e.pl);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, 0, "R1 reset");
    for (int i = 0; i < 2; i++) step(0, 1, 1, 0, 0, 0, "R1 idle");
    // R2 + R7 + R9: select falls, held low past the hold time
    step(0, 0, 1, 0, 0, 0, "R2 ce fall");
    for (int i = 0; i < HOLD + 3; i++) step(0, 0, 1, 0, 0, 0, "R7 R9 timeout with ce low");
    // R10: select rising does not wake
    step(0, 1, 1, 0, 0, 0, "R10 ce rise");
    for (int i = 0; i < 2; i++) step(0, 1, 1, 0, 0, 0, "R10 idle");
    // R3/R10: write strobe falls while deselected
    step(0, 1, 0, 0, 0, 0, "R10 we fall deselected");
    step(0, 1, 0, 0, 0, 0, "R10 hold");
    step(0, 1, 1, 0, 0, 0, "R10 we rise");
    // R4/R10: address moves while deselected
    step(0, 1, 1, 4'h3, 0, 0, "R10 addr move deselected");
    step(0, 1, 1, 4'h9, 0, 0, "R10 addr move deselected");
    // R5/R10: data moves while deselected
    step(0, 1, 1, 4'h9, 4'h5, 0, "R10 data move deselected");
    // R3: write strobe fall while selected (select fell earlier, let it expire)
    step(0, 0, 1, 4'h9, 4'h5, 0, "R2 ce fall");
    for (int i = 0; i < HOLD + 2; i++) step(0, 0, 1, 4'h9, 4'h5, 0, "R7 expire");
    step(0, 0, 0, 4'h9, 4'h5, 0, "R3 we fall selected");
    for (int i = 0; i < HOLD + 2; i++) step(0, 0, 0, 4'h9, 4'h5, 0, "R7 R9 expire in write");
    // R5: data change during selected write
    step(0, 0, 0, 4'h9, 4'hA, 0, "R5 data move in write");
    for (int i = 0; i < HOLD + 1; i++) step(0, 0, 0, 4'h9, 4'hA, 0, "R5 expire");
    // R5/R10: data change while selected but not writing
    step(0, 0, 1, 4'h9, 4'hA, 0, "R10 we rise selected");
    step(0, 0, 1, 4'h9, 4'h1, 0, "R10 data move no write");
    step(0, 0, 1, 4'h9, 4'h2, 0, "R10 data move no write");
    // R4: address change while selected
    step(0, 0, 1, 4'h4, 4'h2, 0, "R4 addr move selected");
    for (int i = 0; i < HOLD + 1; i++) step(0, 0, 1, 4'h4, 4'h2, 0, "R4 expire");
    // R7: retrigger two cycles before expiry reloads full hold
    step(0, 0, 1, 4'h5, 4'h2, 0, "R4 addr move");
    for (int i = 0; i < HOLD - 2; i++) step(0, 0, 1, 4'h5, 4'h2, 0, "R7 hold");
    step(0, 0, 1, 4'h6, 4'h2, 0, "R7 retrigger");
    for (int i = 0; i < HOLD + 2; i++) step(0, 0, 1, 4'h6, 4'h2, 0, "R7 R9 reload then expire");
    // R6: clear while deselected
    step(0, 1, 1, 4'h6, 4'h2, 0, "R10 deselect");
    for (int i = 0; i < HOLD; i++) step(0, 1, 1, 4'h6, 4'h2, 0, "R10 idle");
    step(0, 1, 1, 4'h6, 4'h2, 1, "R6 clr");
    step(0, 1, 1, 4'h6, 4'h2, 0, "R6 after clr");
    step(0, 1, 1, 4'h6, 4'h2, 1, "R6 clr again");
    // R1: reset while awake gives no sleep pulse
    step(1, 1, 1, 4'h6, 4'h2, 0, "R1 reset while awake");
    step(0, 1, 1, 4'h6, 4'h2, 0, "R1 no pulse after reset");
    step(0, 1, 1, 4'h6, 4'h2, 0, "R1 stays asleep");
    // R8 is checked on every item via sleep
    wait (q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule